// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block sits at a root port and catches message-signalled interrupts aimed at the host. Software programs a 64-bit capture address and three 32-bit vector registers through a plain 32-bit register port. The vector registers are an enable, a mask and a pending status. Inbound memory traffic from the link arrives on a valid/ready channel. A full 4-byte write that lands on the capture address is consumed whenever the enable register is nonzero. Its data value names the vector to latch. All other traffic, including reads of the capture address, flows on unchanged to a downstream valid/ready channel.

One level-sensitive interrupt line reports pending work. A capture raises the line when it leaves an unmasked pending bit set. Software acknowledges by writing a value that toggles status bits. The line drops only when the status register becomes entirely zero. Masking pending bits does not drop it.

The channel uses the usual back-pressure rules. A captured beat is always accepted, with `in_ready` high, and is never presented downstream. Any other beat is forwarded combinationally, so `in_ready` follows `out_ready`. A beat on the inbound channel must hold its fields stable until it is accepted. The block adds no storage on the traffic path.

Top module: `msi_catcher`

## Requirements
- R1: After reset, the capture address, enable, mask and status registers read zero, and `irq` is low.
- R2: The capture address is written as two 32-bit halves. The low half is at offset 0x820 and the high half is at 0x824. Writing one half leaves the other half unchanged, and both halves read back what was written.
- R3: A captured write with data v below 32 sets status bit v only if enable bit v is 1. Enable is at offset 0x828 and status is at 0x830.
- R4: A captured write with data of 32 or more is still consumed, but it sets no status bit.
- R5: In the cycle after a capture, `irq` is high if the resulting status has any bit set whose mask bit is 0. Mask is at offset 0x82C. A capture that leaves only masked bits pending does not change `irq`.
- R6: A register write to status XORs the written value into status. If the result is zero, `irq` is low from the next cycle. Otherwise `irq` keeps its value, even when every pending bit is masked.
- R7: While enable is zero, a write to the capture address passes downstream and status does not change.
- R8: A write to the capture address whose size field `in_size` is not 4 bytes passes downstream uncaptured.
- R9: A read that targets the capture address is forwarded downstream like any other read.
- R10: If a capture and a status write happen in the same cycle, the capture bit is applied first, then the XOR. The `irq` rule is evaluated on the combined result.
- R11: A captured beat gives `in_ready`=1 and `out_valid`=0. For any other beat, `out_valid`=`in_valid`, `in_ready`=`out_ready`, and the address, data, size and write fields are copied to the downstream channel.
- R12: Register offsets other than 0x820, 0x824, 0x828, 0x82C and 0x830 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | 64 | Inbound target address |
| in_size | input | 3 | Access size in bytes (1 to 4) |
| in_data | input | 32 | Inbound write data |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_write | output | 1 | Forwarded write flag |
| out_addr | output | 64 | Forwarded address |
| out_size | output | 3 | Forwarded size |
| out_data | output | 32 | Forwarded data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the routing rules on every cycle:
- a captured beat is never forwarded and is always accepted;
- reads always pass through;
- an unmasked enabled capture raises `irq` on the next cycle;
- `irq` never falls except after a status write;
- status stays constant while enable is zero.

Some behaviours can only be shown by the bench's scenarios, driven against the reference model: independent address halves, toggle-clear that leaves masked bits pending, out-of-range vector values, size filtering, and the same-cycle ordering of capture and acknowledge.

// File: rtl/msi_catcher_pkg.sv
package msi_catcher_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_CAP_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFS_CAP_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 12'h828;
  localparam logic [REG_AW-1:0] OFS_MASK   = 12'h82C;
  localparam logic [REG_AW-1:0] OFS_STATUS = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP_LO, SEL_CAP_HI, SEL_ENABLE, SEL_MASK, SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] ofs);
    case (ofs)
      OFS_CAP_LO: return SEL_CAP_LO;
      OFS_CAP_HI: return SEL_CAP_HI;
      OFS_ENABLE: return SEL_ENABLE;
      OFS_MASK:   return SEL_MASK;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/msi_cap_addr.sv
module msi_cap_addr #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  localparam int NHALF = ADDR_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHALF-1:0]  wr_part,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] cap_addr
);
  for (genvar h = 0; h < NHALF; h++) begin : g_part
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_addr[h*DATA_W +: DATA_W] <= '0;
      else if (wr_part[h]) cap_addr[h*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/msi_hit_route.sv
module msi_hit_route #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int FULL_BYTES = DATA_W / 8
) (
  input  logic              armed,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [DATA_W-1:0] out_data,
  output logic              cap_fire
);
  logic addr_hit, full_size;

  always_comb begin
    addr_hit  = (in_addr == cap_addr);
    full_size = (in_size == SIZE_W'(FULL_BYTES));
    cap_fire  = in_valid && in_write && full_size && addr_hit && armed;
    out_valid = in_valid && !cap_fire;
    in_ready  = cap_fire ? 1'b1 : out_ready;
    out_write = in_write;
    out_addr  = in_addr;
    out_size  = in_size;
    out_data  = in_data;
  end
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_mask,
  input  logic            wr_stat,
  input  logic [NVEC-1:0] wdata,
  input  logic            cap_fire,
  input  logic [NVEC-1:0] cap_data,
  output logic [NVEC-1:0] en_q,
  output logic [NVEC-1:0] mask_q,
  output logic [NVEC-1:0] stat_q,
  output logic            irq_q
);
  logic [NVEC-1:0] vec_hit, stat_cap, stat_nxt;
  logic            raise, drop;

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    assign vec_hit[i] = cap_fire && (cap_data == NVEC'(i)) && en_q[i];
  end

  always_comb begin
    stat_cap = stat_q | vec_hit;
    stat_nxt = wr_stat ? (stat_cap ^ wdata) : stat_cap;
    raise    = cap_fire && |(stat_nxt & ~mask_q);
    drop     = wr_stat && (stat_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      stat_q <= stat_nxt;
      if (drop)       irq_q <= 1'b0;
      else if (raise) irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/msi_catcher.sv
module msi_catcher
  import msi_catcher_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int NHALF = ADDR_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [DATA_W-1:0] out_data,
  output logic              irq
);
  reg_sel_e          sel;
  logic [NHALF-1:0]  wr_part;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] en_q, mask_q, stat_q;
  logic              cap_fire;

  assign sel        = decode_ofs(reg_addr);
  assign wr_part[0] = reg_wr && (sel == SEL_CAP_LO);
  assign wr_part[1] = reg_wr && (sel == SEL_CAP_HI);

  msi_cap_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_part(wr_part), .wdata(reg_wdata),
    .cap_addr(cap_addr)
  );

  msi_hit_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_route (
    .armed(|en_q), .cap_addr(cap_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_addr(in_addr), .in_size(in_size), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_addr(out_addr), .out_size(out_size), .out_data(out_data),
    .cap_fire(cap_fire)
  );

  msi_vec_bank #(.NVEC(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && (sel == SEL_ENABLE)),
    .wr_mask(reg_wr && (sel == SEL_MASK)),
    .wr_stat(reg_wr && (sel == SEL_STATUS)),
    .wdata(reg_wdata), .cap_fire(cap_fire), .cap_data(in_data),
    .en_q(en_q), .mask_q(mask_q), .stat_q(stat_q), .irq_q(irq)
  );

  always_comb begin
    case (sel)
      SEL_CAP_LO: reg_rdata = cap_addr[DATA_W-1:0];
      SEL_CAP_HI: reg_rdata = cap_addr[ADDR_W-1:DATA_W];
      SEL_ENABLE: reg_rdata = en_q;
      SEL_MASK:   reg_rdata = mask_q;
      SEL_STATUS: reg_rdata = stat_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_catcher_chk.sv
module msi_catcher_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int VW = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [11:0]       reg_addr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_write,
  input logic [ADDR_W-1:0] in_addr,
  input logic [SIZE_W-1:0] in_size,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              irq,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] stat_q
);
  logic hit, stat_wr, vec_ok;
  assign hit     = in_valid && in_write && (in_size == SIZE_W'(DATA_W / 8))
                   && (in_addr == cap_addr) && (en_q != '0);
  assign stat_wr = reg_wr && (reg_addr == 12'h830);
  assign vec_ok  = (in_data < DATA_W) && en_q[in_data[VW-1:0]]
                   && !mask_q[in_data[VW-1:0]];

  a_r11_captured_taken: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (in_ready && !out_valid));
  a_r11_pass_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (in_ready == out_ready && out_valid == in_valid));
  a_r9_read_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_write) |-> out_valid);
  a_r5_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && vec_ok && !stat_wr) |=> irq);
  a_r6_irq_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr));
  a_r7_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !stat_wr) |=> $stable(stat_q));
endmodule

bind msi_catcher msi_catcher_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
  .in_addr(in_addr), .in_size(in_size), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .irq(irq),
  .cap_addr(cap_addr), .en_q(en_q), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/test_msi_catcher.sv
module test_msi_catcher;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 1'b0, in_ready, in_write = 1'b0;
  logic [63:0] in_addr = '0, out_addr;
  logic [2:0]  in_size = 3'd4, out_size;
  logic [31:0] in_data = '0, out_data;
  logic        out_valid, out_ready = 1'b1, out_write, irq;

  int total = 0, bad = 0;
  string cur_req = "R1";
  logic [31:0] m_lo = 0, m_hi = 0, m_en = 0, m_mask = 0, m_stat = 0;
  logic        m_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_catcher i_msi_catcher (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_addr(in_addr), .in_size(in_size), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_addr(out_addr), .out_size(out_size), .out_data(out_data), .irq(irq)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h820: return m_lo;
      12'h824: return m_hi;
      12'h828: return m_en;
      12'h82C: return m_mask;
      12'h830: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  // one clock: compare outputs against the model, then advance the model
  task automatic tick();
    logic cap;
    logic [31:0] s;
    #(CLK_P/4);
    cap = in_valid && in_write && in_size == 3'd4 && in_addr == {m_hi, m_lo} && m_en != 0;
    check(out_valid, in_valid && !cap, "out_valid");
    check(in_ready, cap ? 1'b1 : out_ready, "in_ready");
    if (out_valid) check(out_addr, in_addr, "out_addr");
    check(reg_rdata, model_read(reg_addr), "reg_rdata");
    check(irq, m_irq, "irq");
    s = m_stat;
    if (cap && in_data < 32) s = s | ((32'h1 << in_data) & m_en);
    if (reg_wr && reg_addr == 12'h830) s = s ^ reg_wdata;
    @(posedge clk);
    if (reg_wr && reg_addr == 12'h830 && s == 0) m_irq = 1'b0;
    else if (cap && (s & ~m_mask) != 0) m_irq = 1'b1;
    m_stat = s;
    if (reg_wr) case (reg_addr)
      12'h820: m_lo = reg_wdata;
      12'h824: m_hi = reg_wdata;
      12'h828: m_en = reg_wdata;
      12'h82C: m_mask = reg_wdata;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rreg(input logic [11:0] a);
    reg_addr = a; tick();
  endtask

  task automatic beat(input logic wr, input logic [63:0] a, input logic [2:0] sz, input logic [31:0] d);
    in_valid = 1; in_write = wr; in_addr = a; in_size = sz; in_data = d;
    tick(); in_valid = 0;
  endtask

  localparam logic [63:0] CAP = 64'h0000_0001_FEE0_0040;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of every register and irq
    cur_req = "R1";
    rreg(12'h820); rreg(12'h824); rreg(12'h828); rreg(12'h82C); rreg(12'h830);
    // R2: halves are independent
    cur_req = "R2";
    wreg(12'h820, CAP[31:0]); rreg(12'h824);
    wreg(12'h824, CAP[63:32]); rreg(12'h820); rreg(12'h824);
    // R7: enable zero means pass through
    cur_req = "R7";
    beat(1, CAP, 3'd4, 32'd3); rreg(12'h830);
    // R3 / R5: enabled capture sets bit and raises irq
    cur_req = "R3";
    wreg(12'h828, 32'h0000_00FF);
    beat(1, CAP, 3'd4, 32'd5); rreg(12'h830);
    beat(1, CAP, 3'd4, 32'd9); rreg(12'h830);
    // R4: vector >= 32 consumed, no bit
    cur_req = "R4";
    beat(1, CAP, 3'd4, 32'd40); beat(1, CAP, 3'd4, 32'd32); rreg(12'h830);
    // R6: ack clears to zero, irq drops
    cur_req = "R6";
    wreg(12'h830, 32'h20); rreg(12'h830);
    // R5: masked capture does not raise irq; unmasked does
    cur_req = "R5";
    wreg(12'h82C, 32'h4);
    beat(1, CAP, 3'd4, 32'd2); rreg(12'h830);
    beat(1, CAP, 3'd4, 32'd3); rreg(12'h830);
    // R6: ack leaving masked bit pending keeps irq
    cur_req = "R6";
    wreg(12'h830, 32'h8); rreg(12'h830);
    wreg(12'h830, 32'h4); rreg(12'h830);
    // R8: partial size passes through
    cur_req = "R8";
    beat(1, CAP, 3'd2, 32'd1); rreg(12'h830);
    // R9: read of capture address passes through
    cur_req = "R9";
    beat(0, CAP, 3'd4, 32'd1); rreg(12'h830);
    // R11: back-pressure on forwarded beat, captured beat still accepted
    cur_req = "R11";
    out_ready = 0;
    beat(1, CAP + 64'h100, 3'd4, 32'd1);
    beat(1, CAP, 3'd4, 32'd0);
    out_ready = 1;
    beat(1, CAP + 64'h100, 3'd4, 32'd1);
    wreg(12'h830, 32'h1);
    // R10: capture and ack together
    cur_req = "R10";
    reg_wr = 1; reg_addr = 12'h830; reg_wdata = 32'h40;
    beat(1, CAP, 3'd4, 32'd6); reg_wr = 0; rreg(12'h830);
    reg_wr = 1; reg_addr = 12'h830; reg_wdata = 32'h1;
    beat(1, CAP, 3'd4, 32'd7); reg_wr = 0; rreg(12'h830);
    reg_wr = 1; reg_addr = 12'h830; reg_wdata = 32'h81;
    beat(1, CAP, 3'd4, 32'd1); reg_wr = 0; rreg(12'h830);
    // R12: unmapped offsets
    cur_req = "R12";
    wreg(12'h834, 32'hFFFF_FFFF); rreg(12'h834);
    wreg(12'h81C, 32'h1234_5678); rreg(12'h81C);
    rreg(12'h820); rreg(12'h824); rreg(12'h828); rreg(12'h82C); rreg(12'h830);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule